// File: doc/BRIEF.md
# Power-of-Two Register Watchdog

This block is a watchdog timer for a board-management controller. Software reaches it through a small byte-wide register bus. A one-millisecond tick comes from a prescaler that divides the system clock. A 4-bit exponent in the threshold register picks the timeout, which is the base interval (15 ticks by default) shifted left by the exponent. The range runs from 15 ms at exponent 0 to about 491.5 s at exponent 15. There is no separate service register. Software keeps the timer alive by rewriting the threshold register, and this restarts the count even when the value written is unchanged.

A control register gates the watchdog through its enable bit. When the count reaches the selected timeout, the block raises a reset request for a fixed number of clock cycles. It also marks the watchdog as the cause in a sticky reset-cause register, and then it stays idle until software writes the threshold or control register again. The cause register also collects flags from host, push-button, thermal, auto-power-off and power-fail sources. A read-only revision register completes the map.

The registers keep their contents until software writes them. Boot firmware can therefore leave the enable bit and the exponent set, and later software finds them unchanged.

Top module: `pow2_wdog`

## Requirements
- R1: With exponent n in bits [3:0] of the threshold register (address 0), the reset request rises exactly (BASE_TICKS << n) × TICK_DIV clock cycles after the write edge that last restarted the count.
- R2: Any write to the threshold register, or to the control register (address 1), restarts the count from zero. Rewriting the same threshold value therefore postpones expiry indefinitely.
- R3: While control bit 0 (enable) is 0, no reset request begins. A control write that sets the bit starts a full timeout from that write.
- R4: The reset request stays high for exactly PULSE_CYC cycles. After an expiry no further request occurs until the threshold or control register is written.
- R5: On expiry, bit 2 (watchdog) of the cause register (address 2) is set.
- R6: Cause bits are sticky. Bit 0 is set by evt_host, bit 1 by evt_button, bit 3 by pwr_fail_in, bit 4 by evt_therm and bit 5 by evt_autooff. Writing 1 to a bit clears it, writing 0 leaves it, and a set in the same cycle wins over a clear.
- R7: After power-on reset the threshold register reads THR_RESET (0x0F), the control register reads 0, the cause register reads 0 while pwr_fail_in is low, and no reset request is active.
- R8: The threshold register keeps all 8 written bits and reads them back. Only bits [3:0] select the timeout.
- R9: Address 3 always reads VERSION (0x21), and writes to it have no effect.
- R10: A read returns data on bus_rdata one cycle after bus_rd. Addresses 4 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| evt_host | input | 1 | Host-requested reset event |
| evt_button | input | 1 | Push-button reset event |
| evt_therm | input | 1 | Thermal trip event |
| evt_autooff | input | 1 | Automatic power-off event |
| pwr_fail_in | input | 1 | Power-fail indication, level-sensitive |
| wdog_rst_req | output | 1 | Reset request pulse on expiry |

## Verification
The assertions assume that the bus strobes and event inputs are synchronous to clk. They also assume that the shortest timeout (BASE_TICKS × TICK_DIV cycles) is longer than PULSE_CYC, so that one reset pulse cannot overlap the next expiry. The stimulus changes every input only on the falling clock edge, never asserts bus_wr and bus_rd together, and uses TICK_DIV = 2 with the default pulse length, so the shortest timeout is 30 cycles against a 16-cycle pulse. Exponents 0 to 4 are exercised in full; larger exponents use the same shifter and comparator.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int N_FLAGS = 6;

  localparam logic [ADDR_W-1:0] ADR_THR   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CAUSE = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_VER   = 3'd3;

  localparam int FB_HOST   = 0;
  localparam int FB_BUTTON = 1;
  localparam int FB_WDOG   = 2;
  localparam int FB_PWR    = 3;
  localparam int FB_THERM  = 4;
  localparam int FB_AUTO   = 5;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int              IDX_W     = 4,
  parameter logic [DATA_W-1:0] THR_RESET = 8'h0F,
  parameter logic [DATA_W-1:0] VERSION   = 8'h21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [N_FLAGS-1:0] flag_set,
  output logic [DATA_W-1:0]  rdata,
  output logic [IDX_W-1:0]   thr_idx,
  output logic               enable,
  output logic               restart
);
  logic [DATA_W-1:0]  thr_q, thr_d;
  logic [DATA_W-1:0]  ctrl_q, ctrl_d;
  logic [N_FLAGS-1:0] cause_q, cause_d;
  logic [DATA_W-1:0]  rdata_d, rd_mux;
  logic               wr_thr, wr_ctrl, wr_cause;

  always_comb begin
    wr_thr   = wr && (addr == ADR_THR);
    wr_ctrl  = wr && (addr == ADR_CTRL);
    wr_cause = wr && (addr == ADR_CAUSE);
    thr_d    = wr_thr  ? wdata : thr_q;
    ctrl_d   = wr_ctrl ? ctrl_q ^ (ctrl_q ^ wdata) : ctrl_q;
    cause_d  = (cause_q & ~(wr_cause ? wdata[N_FLAGS-1:0] : '0)) | flag_set;
    case (addr)
      ADR_THR:   rd_mux = thr_q;
      ADR_CTRL:  rd_mux = ctrl_q;
      ADR_CAUSE: rd_mux = DATA_W'(cause_q);
      ADR_VER:   rd_mux = VERSION;
      default:   rd_mux = '0;
    endcase
    rdata_d = rd ? rd_mux : '0;
    restart = wr_thr | wr_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= THR_RESET;
      ctrl_q  <= '0;
      cause_q <= '0;
      rdata   <= '0;
    end else begin
      thr_q   <= thr_d;
      ctrl_q  <= ctrl_d;
      cause_q <= cause_d;
      rdata   <= rdata_d;
    end
  end

  assign thr_idx = thr_q[IDX_W-1:0];
  assign enable  = ctrl_q[0];
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int TICK_DIV   = 250000,
  parameter int BASE_TICKS = 15,
  parameter int IDX_W      = 4,
  parameter int PULSE_CYC  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             restart,
  input  logic [IDX_W-1:0] idx,
  output logic             expire,
  output logic             rst_req
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam int CNT_W = $clog2(BASE_TICKS + 1) + (1 << IDX_W) - 1;
  localparam int PUL_W = $clog2(PULSE_CYC + 1);

  logic [PRE_W-1:0] presc_q, presc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, limit;
  logic [PUL_W-1:0] pulse_q, pulse_d;
  logic             halt_q, halt_d;
  logic             tick;

  always_comb begin
    limit   = CNT_W'(BASE_TICKS) << idx;
    cnt_inc = cnt_q + CNT_W'(1);
    tick    = (presc_q == PRE_W'(TICK_DIV - 1));
    presc_d = presc_q;
    cnt_d   = cnt_q;
    halt_d  = halt_q;
    expire  = 1'b0;
    pulse_d = (pulse_q != '0) ? pulse_q - PUL_W'(1) : '0;
    if (restart) begin
      presc_d = '0;
      cnt_d   = '0;
      halt_d  = 1'b0;
    end else if (!run_en) begin
      presc_d = '0;
      cnt_d   = '0;
    end else if (!halt_q) begin
      if (tick) begin
        presc_d = '0;
        if (cnt_inc >= limit) begin
          expire  = 1'b1;
          halt_d  = 1'b1;
          cnt_d   = '0;
          pulse_d = PUL_W'(PULSE_CYC);
        end else begin
          cnt_d = cnt_inc;
        end
      end else begin
        presc_d = presc_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
      halt_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
      halt_q  <= halt_d;
      pulse_q <= pulse_d;
    end
  end

  assign rst_req = (pulse_q != '0);
endmodule

// File: rtl/pow2_wdog.sv
`timescale 1ns/1ps
module pow2_wdog
  import wdog_pkg::*;
#(
  parameter int                TICK_DIV   = 250000,
  parameter int                BASE_TICKS = 15,
  parameter int                IDX_W      = 4,
  parameter int                PULSE_CYC  = 16,
  parameter logic [DATA_W-1:0] THR_RESET  = 8'h0F,
  parameter logic [DATA_W-1:0] VERSION    = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_host,
  input  logic              evt_button,
  input  logic              evt_therm,
  input  logic              evt_autooff,
  input  logic              pwr_fail_in,
  output logic              wdog_rst_req
);
  logic [1:0]         rs_q;
  logic               rst_int_n;
  logic [IDX_W-1:0]   thr_idx;
  logic               enable, restart, expire;
  logic [N_FLAGS-1:0] flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    flag_set            = '0;
    flag_set[FB_HOST]   = evt_host;
    flag_set[FB_BUTTON] = evt_button;
    flag_set[FB_WDOG]   = expire;
    flag_set[FB_PWR]    = pwr_fail_in;
    flag_set[FB_THERM]  = evt_therm;
    flag_set[FB_AUTO]   = evt_autooff;
  end

  wdog_regs #(
    .IDX_W(IDX_W), .THR_RESET(THR_RESET), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .flag_set(flag_set), .rdata(bus_rdata),
    .thr_idx(thr_idx), .enable(enable), .restart(restart)
  );

  wdog_timer #(
    .TICK_DIV(TICK_DIV), .BASE_TICKS(BASE_TICKS), .IDX_W(IDX_W), .PULSE_CYC(PULSE_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run_en(enable), .restart(restart),
    .idx(thr_idx), .expire(expire), .rst_req(wdog_rst_req)
  );
endmodule

// File: rtl/pow2_wdog_chk.sv
`timescale 1ns/1ps
module pow2_wdog_chk
  import wdog_pkg::*;
#(
  parameter int                PULSE_CYC = 16,
  parameter logic [DATA_W-1:0] VERSION   = 8'h21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              en,
  input logic              wdog_rst_req
);
  localparam int LEN_W = $clog2(PULSE_CYC + 2);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (wdog_rst_req) len_q <= len_q + LEN_W'(1);
    else len_q <= '0;
  end

  // R2
  keepalive_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_THR) |=> !$rose(wdog_rst_req));
  // R3
  fire_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst_req) |-> $past(en));
  // R4
  pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> (len_q < LEN_W'(PULSE_CYC)));
  // R4
  pulse_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_rst_req) |-> ($past(len_q) == LEN_W'(PULSE_CYC - 1)));
  // R9
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADR_VER) |=> (bus_rdata == VERSION));
  // R10
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[ADDR_W-1]) |=> (bus_rdata == '0));
endmodule

bind pow2_wdog pow2_wdog_chk #(.PULSE_CYC(PULSE_CYC), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .en(enable), .wdog_rst_req(wdog_rst_req)
);

// File: tb/pow2_wdog_test.sv
`timescale 1ns/1ps
module pow2_wdog_test;
  localparam int          DIV  = 2;
  localparam int          PLEN = 16;
  localparam logic [7:0]  VER  = 8'h21;
  localparam int          NV   = 6;
  localparam logic [7:0]  VEC_THR [NV] = '{8'h00, 8'hA1, 8'h52, 8'hF3, 8'h34, 8'h01};
  localparam int          VEC_EXP [NV] = '{30, 60, 120, 240, 480, 60};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       evt_host = 0, evt_button = 0, evt_therm = 0, evt_autooff = 0, pwr_fail_in = 0;
  logic       wdog_rst_req;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  pow2_wdog #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_host(evt_host),
    .evt_button(evt_button), .evt_therm(evt_therm), .evt_autooff(evt_autooff),
    .pwr_fail_in(pwr_fail_in), .wdog_rst_req(wdog_rst_req)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_req(output int n, input int maxc);
    n = 0;
    while (!wdog_rst_req && n < maxc) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_len(output int len);
    len = 0;
    while (wdog_rst_req && len < 100) begin len++; @(negedge clk); end
  endtask

  task automatic quiet(input int cyc, output int highs);
    highs = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (wdog_rst_req) highs++; end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, len, hi;
    repeat (3) @(negedge clk);
    check_eq("R7 req in reset", wdog_rst_req, 0);
    check_eq("R7 rdata in reset", bus_rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(3'd0, d); check_eq("R7 thr reset", d, 8'h0F);
    bus_read(3'd1, d); check_eq("R7 ctrl reset", d, 0);
    bus_read(3'd2, d); check_eq("R7 cause reset", d, 0);
    bus_read(3'd3, d); check_eq("R9 version", d, VER);
    bus_write(3'd3, 8'hFF);
    bus_read(3'd3, d); check_eq("R9 version after write", d, VER);
    bus_write(3'd5, 8'hFF);
    bus_read(3'd5, d); check_eq("R10 undefined read", d, 0);
    bus_read(3'd0, d); check_eq("R10 thr untouched", d, 8'h0F);
    bus_read(3'd1, d); check_eq("R10 ctrl untouched", d, 0);

    // R6 event flags
    @(negedge clk); evt_host = 1; evt_therm = 1;
    @(negedge clk); evt_host = 0; evt_therm = 0;
    bus_read(3'd2, d); check_eq("R6 set host+therm", d, 8'h11);
    bus_write(3'd2, 8'h00);
    bus_read(3'd2, d); check_eq("R6 write zero keeps", d, 8'h11);
    bus_write(3'd2, 8'h01);
    bus_read(3'd2, d); check_eq("R6 w1c host", d, 8'h10);
    @(negedge clk); evt_button = 1; evt_autooff = 1; pwr_fail_in = 1;
    @(negedge clk); evt_button = 0; evt_autooff = 0; pwr_fail_in = 0;
    bus_read(3'd2, d); check_eq("R6 R7 more flags", d, 8'h3A);
    bus_write(3'd2, 8'h3A);
    bus_read(3'd2, d); check_eq("R6 clear all", d, 0);

    // R3 disabled at reset: no request even with idx 0
    bus_write(3'd0, 8'h00);
    quiet(100, hi); check_eq("R3 disabled quiet", hi, 0);
    bus_write(3'd1, 8'h01);

    for (int v = 0; v < NV; v++) begin
      bus_write(3'd0, VEC_THR[v]);
      wait_req(n, 2000); check_eq("R1 timeout", n, VEC_EXP[v]);
      pulse_len(len);    check_eq("R4 pulse length", len, PLEN);
      quiet(100, hi);    check_eq("R4 held after expiry", hi, 0);
      bus_read(3'd0, d); check_eq("R8 thr readback", d, VEC_THR[v]);
      bus_read(3'd2, d); check_eq("R5 wdog flag", d, 8'h04);
      bus_write(3'd2, 8'h04);
      bus_read(3'd2, d); check_eq("R6 wdog flag cleared", d, 0);
    end

    // R2 keepalive by rewriting the same value
    hi = 0;
    for (int k = 0; k < 5; k++) begin
      int h;
      bus_write(3'd0, 8'h01);
      quiet(40, h); hi += h;
    end
    check_eq("R2 keepalive quiet", hi, 0);
    bus_write(3'd0, 8'h01);
    wait_req(n, 2000); check_eq("R2 timeout after last kick", n, 60);
    pulse_len(len);

    // R1 R2 index change mid-run
    bus_write(3'd0, 8'h03);
    quiet(100, hi); check_eq("R1 long idx quiet", hi, 0);
    bus_write(3'd0, 8'h00);
    wait_req(n, 2000); check_eq("R1 index change", n, 30);
    pulse_len(len);

    // R3 disable stops, enable restarts full timeout
    bus_write(3'd0, 8'h00);
    bus_write(3'd1, 8'h00);
    quiet(200, hi); check_eq("R3 disabled no fire", hi, 0);
    bus_read(3'd1, d); check_eq("R3 ctrl readback", d, 0);
    bus_write(3'd1, 8'h01);
    wait_req(n, 2000); check_eq("R3 timeout from enable", n, 30);
    pulse_len(len); check_eq("R4 pulse after enable", len, PLEN);

    summary();
    $finish;
  end
endmodule